// File: doc/BRIEF.md
# Full/Low-Speed Serial Bit-Timing Recovery

This block recovers bit timing and data from the single-ended, NRZI-coded output of an external differential receiver. Only one timing source is available: the 48 MHz system clock. The block oversamples the line at that rate. A speed-select input picks the bit period: 4 clock cycles for the 12 Mb/s full-speed rate, or 32 clock cycles for the 1.5 Mb/s low-speed rate. The transmit-side state machine drives this input.

A phase counter restarts on every transition of the received data and wraps at the selected period. The line level is captured shortly before the middle of each bit. Each captured bit is presented with a strobe that lasts one cycle. The raw D+ and D- levels are watched in parallel, so a single-ended-zero state can be flagged.

Downstream logic, such as the NRZI decoder and the sync and bit-stuff logic, consumes the recovered bit only in cycles where the strobe is high.

Top module: `fsls_clock_recovery`

## Requirements
- R1: While reset is asserted, `bitValid`, `bitData` and `se0` are all 0.
- R2: With `lowSpeed` = 0, each bit held on `rxData` for 4 cycles produces exactly one `bitValid` pulse. `bitData` equals that bit's line level while the pulse is high, and bits come out in the order they were sent.
- R3: With `lowSpeed` = 1, each bit held for 32 cycles produces exactly one `bitValid` pulse carrying that bit's level.
- R4: The phase counter restarts on every data transition. At full speed, an alternating stream whose bits last 3, 4 or 5 cycles is still recovered with one pulse per bit.
- R5: `bitValid` is never high in two consecutive cycles.
- R6: `se0` rises 2 cycles after `linePos` and `lineNeg` have both been sampled low for a full bit period: 4 cycles at full speed, 32 at low speed. Concretely, lines first low before clock edge k gives `se0` high from edge k+P+1. A low interval one cycle shorter than the period never raises `se0`.
- R7: `se0` falls 3 clock edges after either line returns high. Lines high before edge m gives `se0` low from edge m+2.
- R8: `bitValid` is 0 in every cycle where `se0` is 1.
- R9: A change of `lowSpeed` before edge k reloads the phase counter. It also forces `bitValid` to 0 after edge k.
- R10: With `rxData` held constant and no SE0, `bitValid` pulses repeat every 4 cycles at full speed and every 32 cycles at low speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowSpeed | input | 1 | 1 selects the 32-cycle low-speed period; 0 selects the 4-cycle full-speed period |
| rxData | input | 1 | NRZI data from the differential receiver (asynchronous) |
| linePos | input | 1 | Raw D+ level (asynchronous) |
| lineNeg | input | 1 | Raw D- level (asynchronous) |
| bitData | output | 1 | Recovered line level, valid while bitValid is high |
| bitValid | output | 1 | One-cycle strobe for each recovered bit |
| se0 | output | 1 | Both lines low for at least one bit period |

## Verification
The bench checks the jitter boundary by sending 3-cycle full-speed bits. If the sample point were placed at or after the half-period, the sampling cycle would coincide with the next transition's reload and the bit would be lost. The bench checks SE0 length exactly: a low interval one cycle short of a bit period must not raise the flag, and the rise and fall cycles are checked against fixed counts. An off-by-one counter would flag glitches or react late. The speed select is toggled at eight consecutive phase offsets to catch a stray strobe when the counter reloads. The bench also holds the data line steady during SE0, so a design that failed to suppress strobes would emit data pulses there.

// File: rtl/fsls_cr_pkg.sv
package fsls_cr_pkg;

  // Status from the datapath to the control
  typedef struct packed {
    logic edgeSeen;   // synchronised data changed this cycle
    logic atCentre;   // phase counter at the sampling point
    logic bothLow;    // synchronised D+ and D- both low
  } dpStatT;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic reload;     // restart the phase counter
    logic capture;    // take the current line level as a bit
  } ctlCmdT;

endpackage

// File: rtl/fsls_cr_datapath.sv
module fsls_cr_datapath
  import fsls_cr_pkg::*;
#(
  parameter int FS_PERIOD   = 4,
  parameter int LS_PERIOD   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   lowSpeed,
  input  logic   rxData,
  input  logic   linePos,
  input  logic   lineNeg,
  input  ctlCmdT cmd,
  output dpStatT stat,
  output logic   bitData
);

  localparam int PH_W = $clog2(LS_PERIOD);
  localparam logic [PH_W-1:0] FS_LAST = PH_W'(FS_PERIOD - 1);
  localparam logic [PH_W-1:0] LS_LAST = PH_W'(LS_PERIOD - 1);
  localparam logic [PH_W-1:0] FS_MID  = PH_W'(FS_PERIOD / 2 - 1);
  localparam logic [PH_W-1:0] LS_MID  = PH_W'(LS_PERIOD / 2 - 1);

  // Synchroniser chains: index 0 = line, 1 = D+, 2 = D-
  logic [2:0] rawIn;
  logic [2:0] syncOut;
  assign rawIn = {lineNeg, linePos, rxData};

  for (genvar g = 0; g < 3; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic rxPrev;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] periodLast;
  logic [PH_W-1:0] centre;

  assign periodLast = lowSpeed ? LS_LAST : FS_LAST;
  assign centre     = lowSpeed ? LS_MID  : FS_MID;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev  <= 1'b0;
      phase   <= '0;
      bitData <= 1'b0;
    end else begin
      rxPrev <= syncOut[0];
      if (cmd.reload || phase == periodLast) phase <= '0;
      else                                   phase <= phase + 1'b1;
      if (cmd.capture) bitData <= syncOut[0];
    end
  end

  assign stat.edgeSeen = syncOut[0] != rxPrev;
  assign stat.atCentre = phase == centre;
  assign stat.bothLow  = !syncOut[1] && !syncOut[2];

endmodule

// File: rtl/fsls_cr_control.sv
module fsls_cr_control
  import fsls_cr_pkg::*;
#(
  parameter int FS_PERIOD = 4,
  parameter int LS_PERIOD = 32
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   lowSpeed,
  input  dpStatT stat,
  output ctlCmdT cmd,
  output logic   bitValid,
  output logic   se0
);

  localparam int CNT_W = $clog2(LS_PERIOD);
  localparam logic [CNT_W-1:0] FS_LAST = CNT_W'(FS_PERIOD - 1);
  localparam logic [CNT_W-1:0] LS_LAST = CNT_W'(LS_PERIOD - 1);

  logic             speedQ;
  logic [CNT_W-1:0] lowCnt;
  logic [CNT_W-1:0] lowLimit;
  logic             se0Next;

  assign lowLimit = lowSpeed ? LS_LAST : FS_LAST;
  assign se0Next  = stat.bothLow && (se0 || lowCnt >= lowLimit);

  assign cmd.reload  = stat.edgeSeen || (lowSpeed != speedQ);
  assign cmd.capture = stat.atCentre && !cmd.reload && !se0Next;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedQ   <= 1'b0;
      lowCnt   <= '0;
      se0      <= 1'b0;
      bitValid <= 1'b0;
    end else begin
      speedQ   <= lowSpeed;
      se0      <= se0Next;
      bitValid <= cmd.capture;
      if (!stat.bothLow)        lowCnt <= '0;
      else if (lowCnt < LS_LAST) lowCnt <= lowCnt + 1'b1;
    end
  end

endmodule

// File: rtl/fsls_clock_recovery.sv
module fsls_clock_recovery
  import fsls_cr_pkg::*;
#(
  parameter int FS_PERIOD   = 4,
  parameter int LS_PERIOD   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lowSpeed,
  input  logic rxData,
  input  logic linePos,
  input  logic lineNeg,
  output logic bitData,
  output logic bitValid,
  output logic se0
);

  dpStatT stat;
  ctlCmdT cmd;

  fsls_cr_datapath #(
    .FS_PERIOD(FS_PERIOD), .LS_PERIOD(LS_PERIOD), .SYNC_STAGES(SYNC_STAGES)
  ) dpI (
    .clk(clk), .rstN(rstN), .lowSpeed(lowSpeed), .rxData(rxData),
    .linePos(linePos), .lineNeg(lineNeg), .cmd(cmd), .stat(stat),
    .bitData(bitData)
  );

  fsls_cr_control #(
    .FS_PERIOD(FS_PERIOD), .LS_PERIOD(LS_PERIOD)
  ) ctlI (
    .clk(clk), .rstN(rstN), .lowSpeed(lowSpeed), .stat(stat), .cmd(cmd),
    .bitValid(bitValid), .se0(se0)
  );

endmodule

// File: rtl/fsls_cr_checker.sv
module fsls_cr_checker (
  input logic clk,
  input logic rstN,
  input logic lowSpeed,
  input logic linePos,
  input logic lineNeg,
  input logic bitData,
  input logic bitValid,
  input logic se0
);

  // R1: outputs cleared while reset is held
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!bitValid && !se0 && !bitData)
        else $error("reset state violated");
    end
  end

  // R5: strobe lasts one cycle
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |=> !bitValid);

  // R8: no strobe during SE0
  assert_quiet_in_se0_R8: assert property (@(posedge clk) disable iff (!rstN)
    se0 |-> !bitValid);

  // R9: speed change suppresses the following strobe
  assert_speed_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (lowSpeed != $past(lowSpeed)) |=> !bitValid);

  // R6: SE0 only after the raw lines were low three samples earlier
  assert_se0_needs_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    se0 |-> $past(!linePos && !lineNeg, 3));

  // R7: a line seen high forces SE0 off shortly after
  assert_se0_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(linePos || lineNeg, 3) |-> !se0);

endmodule

bind fsls_clock_recovery fsls_cr_checker chkI (
  .clk(clk), .rstN(rstN), .lowSpeed(lowSpeed), .linePos(linePos),
  .lineNeg(lineNeg), .bitData(bitData), .bitValid(bitValid), .se0(se0)
);

// File: tb/fsls_clock_recovery_tb.sv
module fsls_clock_recovery_tb_top;

  localparam int FS_P = 4;
  localparam int LS_P = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowSpeed = 1'b0;
  logic rxData = 1'b1;
  logic linePos = 1'b1;
  logic lineNeg = 1'b0;
  logic bitData, bitValid, se0;

  int checks = 0;
  int fails = 0;
  logic expQ[$];
  bit strict = 1'b0;
  string curTag = "R2";

  always #5 clk = ~clk;

  fsls_clock_recovery dut_i (
    .clk(clk), .rstN(rstN), .lowSpeed(lowSpeed), .rxData(rxData),
    .linePos(linePos), .lineNeg(lineNeg), .bitData(bitData),
    .bitValid(bitValid), .se0(se0)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: scoreboard pops on each strobe
  always @(negedge clk) begin
    if (rstN && bitValid) begin
      if (expQ.size() > 0) begin
        logic e;
        e = expQ.pop_front();
        check(bitData == e, curTag, int'(bitData), int'(e));
      end else if (strict) begin
        check(1'b0, curTag, 1, 0);  // unexpected extra strobe
      end
    end
  end

  // Driver: hold one bit for len cycles, push its expected level mid-bit
  task automatic sendBit(input logic lvl, input int len, input int centre);
    int pushAt;
    pushAt = (len - 1 < centre + 2) ? len - 1 : centre + 2;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      rxData = lvl; linePos = lvl; lineNeg = !lvl;
      if (i == pushAt) begin
        expQ.push_back(lvl);
        strict = 1'b1;
      end
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    strict = 1'b0;
    check(1'b1, curTag, 0, 0);
  endtask

  task automatic sendIdle(input int cyc);
    @(posedge clk); #1;
    rxData = 1'b1; linePos = 1'b1; lineNeg = 1'b0;
    repeat (cyc) @(posedge clk);
  endtask

  task automatic measureGap(input int exp, input string tag);
    time t0;
    do @(negedge clk); while (!bitValid);
    t0 = $time;
    do @(negedge clk); while (!bitValid);
    check(($time - t0) / 10 == exp, tag, int'(($time - t0) / 10), exp);
  endtask

  task automatic se0Test(input int p);
    bit seen;
    int firstIdx;
    // R6 boundary: one cycle short of a period
    @(posedge clk); #1; linePos = 1'b0; lineNeg = 1'b0;
    repeat (p - 2) @(posedge clk);
    @(posedge clk); #1; linePos = 1'b1; lineNeg = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 2 * p; i++) begin
      @(negedge clk);
      if (se0) seen = 1'b1;
    end
    check(!seen, "R6", int'(seen), 0);
    // full SE0
    @(posedge clk); #1; linePos = 1'b0; lineNeg = 1'b0;
    firstIdx = -1;
    for (int i = 0; i < 3 * p; i++) begin
      @(negedge clk);
      if (se0 && firstIdx < 0) firstIdx = i;
      if (se0) check(!bitValid, "R8", int'(bitValid), 0);
    end
    check(firstIdx == p + 2, "R6", firstIdx, p + 2);
    @(posedge clk); #1; linePos = 1'b1; lineNeg = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(se0 == 1'b1, "R7", int'(se0), 1);
    @(negedge clk);
    check(se0 == 1'b0, "R7", int'(se0), 0);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [19:0] pat;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!bitValid && !se0 && !bitData, "R1", int'({bitValid, se0, bitData}), 0);
    @(posedge clk); #1; rstN = 1'b1;
    sendIdle(20);

    // R10: full-speed cadence on a steady line
    measureGap(FS_P, "R10");

    // R2: full-speed packet starting with a transition
    curTag = "R2";
    pat = 20'b1011_1111_0001_0110_1010;
    sendBit(1'b0, FS_P, FS_P / 2 - 1);
    for (int i = 0; i < 20; i++) sendBit(pat[i], FS_P, FS_P / 2 - 1);
    drain();
    sendIdle(12);

    // R4: jittered alternating stream at full speed
    curTag = "R4";
    sendBit(1'b0, 4, FS_P / 2 - 1);
    for (int i = 0; i < 18; i++) sendBit(i[0], 3 + (i % 3), FS_P / 2 - 1);
    drain();
    sendIdle(12);

    // R6/R7/R8 at full speed
    se0Test(FS_P);
    sendIdle(10);

    // R9: toggle speed at several phase offsets
    for (int off = 0; off < 8; off++) begin
      repeat (off) @(posedge clk);
      @(posedge clk); #1; lowSpeed = ~lowSpeed;
      @(negedge clk); @(negedge clk);
      check(!bitValid, "R9", int'(bitValid), 0);
    end
    // lowSpeed is back to 0 after an even number of toggles
    @(posedge clk); #1; lowSpeed = 1'b1;
    sendIdle(40);

    // R10: low-speed cadence
    measureGap(LS_P, "R10");

    // R3: low-speed packet
    curTag = "R3";
    pat = 20'b0110_0011_1010_0100_1101;
    sendBit(1'b0, LS_P, LS_P / 2 - 1);
    for (int i = 0; i < 12; i++) sendBit(pat[i], LS_P, LS_P / 2 - 1);
    drain();
    sendIdle(40);

    // R6/R7/R8 at low speed
    se0Test(LS_P);
    sendIdle(40);

    // back to full speed, short packet
    @(posedge clk); #1; lowSpeed = 1'b0;
    sendIdle(10);
    curTag = "R2";
    sendBit(1'b0, FS_P, FS_P / 2 - 1);
    for (int i = 0; i < 8; i++) sendBit(pat[i], FS_P, FS_P / 2 - 1);
    drain();
    sendIdle(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule